// File: doc/BRIEF.md
# Table-Driven Packet Header Parser

This block walks the leading bytes of each packet, one byte per clock, and pulls the link-layer header fields into a set of output registers. The byte stream arrives with a valid qualifier and an end-of-packet marker. Stall cycles inside a packet are allowed. The payload is not stored. Once the parser has stopped for a packet, it lets the remaining bytes go by untouched.

The parser does not use fixed case logic to decide which header comes next. At the last byte of each header it forms the 16-bit type field of that header and looks it up in a small writable rule table. Each rule names the header it applies to, gives either a 16-bit value to compare or a wildcard, and names the next state. The supported headers are an Ethernet header, a single VLAN tag, a 6-byte hierarchical route tag (four one-byte route hops plus a type field), and the detection of an IPv4 header.

For each packet the parser presents the following results. They hold until the first byte of the next packet:

- the captured fields;
- a header-present vector;
- an error flag;
- a one-cycle completion strobe.

Rules are written through a simple configuration port. A write is accepted only while the parser is idle between packets.

Top module: `hp_parser`

## Requirements
- R1: The first byte of every packet belongs to the Ethernet header. Bytes 0-5 form `eth_dst`, bytes 6-11 form `eth_src` and bytes 12-13 form `eth_type`. In each field the earliest byte is the most significant.
- R2: The bits of `hdr_valid` are: bit 0 Ethernet, bit 1 VLAN, bit 2 route tag, bit 3 IPv4. A header's bit rises only once all of its bytes have been taken (Ethernet 14, VLAN 4, route tag 6). VLAN bytes 0-1 split into `vlan_pcp` [15:13], `vlan_cfi` [12] and `vlan_vid` [11:0], and bytes 2-3 form `vlan_type`. Route tag bytes 0-3 form `route_tag`, with the first hop in [31:24], and bytes 4-5 form `route_type`.
- R3: The state codes are: start 0, Ethernet 1, VLAN 2, route tag 3, IPv4 4, stop 5. At the last byte of a header, the key {previous byte, current byte} is looked up among the enabled rules whose current-state field equals that header's code. The matching rule selects the next state.
- R4: When several enabled rules match, the one with the lowest index wins. A rule with the wildcard bit set matches any key. A rule that is not enabled never matches.
- R5: A key with no matching rule ends parsing and sets `parse_err`.
- R6: A next state of stop ends parsing without error. A next state of IPv4 sets `hdr_valid[3]` and ends parsing without error, and takes no further bytes.
- R7: A packet that ends before the header in progress is complete ends parsing with `parse_err` set. This includes a packet that ends exactly at a header boundary whose rule names another header. The incomplete header's valid bit stays 0.
- R8: A rule that leads back into a header already taken in the same packet ends parsing with `parse_err` set.
- R9: `parse_done` is high for exactly one cycle per packet, on the cycle after parsing stops. Bytes after that point change no output.
- R10: A rule write is accepted only in a cycle where the parser is idle and `in_valid` is low. A write attempted in any other cycle is dropped.
- R11: After reset, and from the cycle after the first byte of each packet, `hdr_valid` and `parse_err` read 0. The results then hold until the first byte of the next packet.
- R12: Cycles with `in_valid` low inside a packet stall the parser without changing its results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte qualifier |
| in_byte | input | 8 | Packet byte |
| in_last | input | 1 | Marks the final byte of a packet |
| cfg_we | input | 1 | Rule write request |
| cfg_idx | input | 4 | Rule index |
| cfg_en | input | 1 | Rule enable |
| cfg_cur | input | 3 | Header state the rule applies to |
| cfg_wild | input | 1 | Rule matches any key |
| cfg_val | input | 16 | Key to compare |
| cfg_nxt | input | 3 | Next state on match |
| eth_dst | output | 48 | Ethernet destination |
| eth_src | output | 48 | Ethernet source |
| eth_type | output | 16 | Ethernet type |
| vlan_pcp | output | 3 | VLAN priority |
| vlan_cfi | output | 1 | VLAN format bit |
| vlan_vid | output | 12 | VLAN ID |
| vlan_type | output | 16 | Type after the VLAN tag |
| route_tag | output | 32 | Four route hops, first hop in [31:24] |
| route_type | output | 16 | Type after the route tag |
| hdr_valid | output | 4 | Header-present bits |
| parse_err | output | 1 | Parse error |
| parse_done | output | 1 | One-cycle completion strobe |

## Verification
Two kinds of event can fall in the same cycle.

The first is a header's last byte arriving together with the end-of-packet marker. Here the rule lookup and the truncation check decide the result jointly. Packets cut exactly at the 14-byte Ethernet boundary are sent twice: once with a type whose rule ends parsing, where no error is expected, and once with a type whose rule names VLAN, where an error is expected.

The second is a rule write arriving on a cycle that carries a packet byte, or during a stall inside a packet. The bench holds a conflicting write request asserted throughout a packet, including its stalls. It then checks that the packet and a following packet both still parse under the old rule.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int ST_W      = 3;
  localparam int KEY_W     = 16;
  localparam int ETH_BYTES = 14;
  localparam int VLAN_BYTES = 4;
  localparam int RTAG_BYTES = 6;
  localparam int HV_W      = 4;

  typedef enum logic [ST_W-1:0] {
    ST_START = 3'd0, ST_ETH = 3'd1, ST_VLAN = 3'd2,
    ST_RTAG  = 3'd3, ST_IPV4 = 3'd4, ST_STOP = 3'd5
  } hstate_t;

  typedef enum logic [1:0] {P_IDLE, P_HDR, P_DRAIN} phase_t;

  typedef struct packed {
    logic             en;
    logic [ST_W-1:0]  cur;
    logic             wild;
    logic [KEY_W-1:0] val;
    logic [ST_W-1:0]  nxt;
  } rule_t;

  // byte length of each header state
  function automatic logic [3:0] hdr_len(logic [ST_W-1:0] s);
    case (s)
      ST_ETH:  return 4'(ETH_BYTES);
      ST_VLAN: return 4'(VLAN_BYTES);
      ST_RTAG: return 4'(RTAG_BYTES);
      default: return 4'd1;
    endcase
  endfunction

  // position of a header in the valid vector
  function automatic logic [1:0] hv_index(logic [ST_W-1:0] s);
    case (s)
      ST_ETH:  return 2'd0;
      ST_VLAN: return 2'd1;
      ST_RTAG: return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  function automatic logic is_header(logic [ST_W-1:0] s);
    return (s == ST_ETH) || (s == ST_VLAN) || (s == ST_RTAG);
  endfunction
endpackage

// File: rtl/hp_rule_table.sv
module hp_rule_table
  import hp_pkg::*;
#(
  parameter int NUM_RULES = 16,
  localparam int IDX_W = $clog2(NUM_RULES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  rule_t            wr_rule,
  input  logic [ST_W-1:0]  look_state,
  input  logic [KEY_W-1:0] look_key,
  output logic             hit,
  output logic [ST_W-1:0]  hit_next
);
  rule_t rules [NUM_RULES];
  logic [NUM_RULES-1:0] match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_RULES; i++) rules[i] <= '0;
    end else if (wr_en) begin
      rules[wr_idx] <= wr_rule;
    end
  end

  for (genvar g = 0; g < NUM_RULES; g++) begin : g_match
    assign match[g] = rules[g].en && (rules[g].cur == look_state) &&
                      (rules[g].wild || rules[g].val == look_key);
  end

  // lowest index wins: scan downward so the last assignment is the lowest hit
  always_comb begin
    hit      = 1'b0;
    hit_next = ST_STOP;
    for (int i = NUM_RULES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit      = 1'b1;
        hit_next = rules[i].nxt;
      end
    end
  end
endmodule

// File: rtl/hp_capture.sv
module hp_capture
  import hp_pkg::*;
#(
  localparam int ETH_W  = 8 * ETH_BYTES,
  localparam int VLAN_W = 8 * VLAN_BYTES,
  localparam int RTAG_W = 8 * RTAG_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ST_W-1:0]   sel,
  input  logic [7:0]        data,
  output logic [ETH_W-1:0]  eth_q,
  output logic [VLAN_W-1:0] vlan_q,
  output logic [RTAG_W-1:0] rtag_q,
  output logic [7:0]        low_byte
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eth_q  <= '0;
      vlan_q <= '0;
      rtag_q <= '0;
    end else if (en) begin
      case (sel)
        ST_ETH:  eth_q  <= {eth_q[ETH_W-9:0], data};
        ST_VLAN: vlan_q <= {vlan_q[VLAN_W-9:0], data};
        ST_RTAG: rtag_q <= {rtag_q[RTAG_W-9:0], data};
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      ST_VLAN: low_byte = vlan_q[7:0];
      ST_RTAG: low_byte = rtag_q[7:0];
      default: low_byte = eth_q[7:0];
    endcase
  end
endmodule

// File: rtl/hp_parser.sv
module hp_parser
  import hp_pkg::*;
#(
  parameter int NUM_RULES = 16,
  localparam int IDX_W = $clog2(NUM_RULES),
  localparam int CNT_W = $clog2(ETH_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic             in_last,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_en,
  input  logic [ST_W-1:0]  cfg_cur,
  input  logic             cfg_wild,
  input  logic [KEY_W-1:0] cfg_val,
  input  logic [ST_W-1:0]  cfg_nxt,
  output logic [47:0]      eth_dst,
  output logic [47:0]      eth_src,
  output logic [15:0]      eth_type,
  output logic [2:0]       vlan_pcp,
  output logic             vlan_cfi,
  output logic [11:0]      vlan_vid,
  output logic [15:0]      vlan_type,
  output logic [31:0]      route_tag,
  output logic [15:0]      route_type,
  output logic [HV_W-1:0]  hdr_valid,
  output logic             parse_err,
  output logic             parse_done
);
  phase_t           phase;
  logic [ST_W-1:0]  cur_hdr;
  logic [CNT_W-1:0] cnt;
  logic [HV_W-1:0]  hv_q;
  logic             err_q, done_q;

  // named internal events
  logic first, hdr_byte, at_end, tbl_wr;
  logic hit, is_cont, is_final_ok, revisit;
  logic end_err, short_err, stop_evt, miss_evt;
  logic [ST_W-1:0]  nxt;
  logic [7:0]       low_byte;
  logic [KEY_W-1:0] key;
  logic [8*ETH_BYTES-1:0]  eth_q;
  logic [8*VLAN_BYTES-1:0] vlan_q;
  logic [8*RTAG_BYTES-1:0] rtag_q;

  assign tbl_wr = cfg_we && (phase == P_IDLE) && !in_valid;

  hp_rule_table #(.NUM_RULES(NUM_RULES)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_wr), .wr_idx(cfg_idx),
    .wr_rule('{en: cfg_en, cur: cfg_cur, wild: cfg_wild, val: cfg_val, nxt: cfg_nxt}),
    .look_state(cur_hdr), .look_key(key),
    .hit(hit), .hit_next(nxt)
  );

  hp_capture u_cap (
    .clk(clk), .rst_n(rst_n),
    .en(first || hdr_byte),
    .sel(first ? ST_ETH : cur_hdr),
    .data(in_byte),
    .eth_q(eth_q), .vlan_q(vlan_q), .rtag_q(rtag_q),
    .low_byte(low_byte)
  );

  always_comb begin
    first       = in_valid && (phase == P_IDLE);
    hdr_byte    = in_valid && (phase == P_HDR);
    at_end      = hdr_byte && (cnt == CNT_W'(hdr_len(cur_hdr) - 4'd1));
    key         = {low_byte, in_byte};
    is_cont     = hit && is_header(nxt);
    is_final_ok = hit && ((nxt == ST_STOP) || (nxt == ST_IPV4));
    revisit     = is_cont && (hv_q[hv_index(nxt)] || (nxt == cur_hdr));
    end_err     = at_end && (!hit || (!is_cont && !is_final_ok) ||
                             (is_cont && (revisit || in_last)));
    short_err   = (first && in_last) || (hdr_byte && !at_end && in_last);
    stop_evt    = short_err || (at_end && (end_err || is_final_ok));
    miss_evt    = at_end && !hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= P_IDLE;
      cur_hdr <= ST_START;
      cnt     <= '0;
      hv_q    <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= stop_evt;
      if (first) begin
        hv_q    <= '0;
        err_q   <= in_last;
        cur_hdr <= ST_ETH;
        cnt     <= CNT_W'(1);
        phase   <= in_last ? P_IDLE : P_HDR;
      end else if (hdr_byte) begin
        if (at_end) hv_q[hv_index(cur_hdr)] <= 1'b1;
        if (at_end && is_final_ok && (nxt == ST_IPV4)) hv_q[hv_index(ST_IPV4)] <= 1'b1;
        if (stop_evt) begin
          err_q <= end_err || short_err;
          phase <= in_last ? P_IDLE : P_DRAIN;
        end else if (at_end) begin
          cur_hdr <= nxt;
          cnt     <= '0;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end else if ((phase == P_DRAIN) && in_valid && in_last) begin
        phase <= P_IDLE;
      end
    end
  end

  assign eth_dst    = eth_q[111:64];
  assign eth_src    = eth_q[63:16];
  assign eth_type   = eth_q[15:0];
  assign vlan_pcp   = vlan_q[31:29];
  assign vlan_cfi   = vlan_q[28];
  assign vlan_vid   = vlan_q[27:16];
  assign vlan_type  = vlan_q[15:0];
  assign route_tag  = rtag_q[47:16];
  assign route_type = rtag_q[15:0];
  assign hdr_valid  = hv_q;
  assign parse_err  = err_q;
  assign parse_done = done_q;
endmodule

// File: rtl/hp_checker.sv
module hp_checker
  import hp_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            stop_evt,
  input logic            miss_evt,
  input logic            tbl_wr,
  input phase_t          phase,
  input logic            parse_done,
  input logic            parse_err,
  input logic [HV_W-1:0] hdr_valid
);
  assert_done_after_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> parse_done);

  assert_done_outside_header_R9: assert property (@(posedge clk) disable iff (!rst_n)
    parse_done |-> (phase != P_HDR));

  assert_miss_sets_error_R5: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |=> parse_err);

  assert_error_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(parse_err) |-> parse_done);

  assert_write_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wr |=> !parse_done);

  assert_vlan_after_eth_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid[1] |-> hdr_valid[0]);

  assert_tag_after_eth_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid[2] |-> hdr_valid[0]);
endmodule

bind hp_parser hp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .stop_evt(stop_evt), .miss_evt(miss_evt),
  .tbl_wr(tbl_wr), .phase(phase), .parse_done(parse_done),
  .parse_err(parse_err), .hdr_valid(hdr_valid)
);

// File: tb/sim_hp_parser.sv
module sim_hp_parser;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_byte = '0;
  logic cfg_we = 1'b0, cfg_en = 1'b0, cfg_wild = 1'b0;
  logic [3:0] cfg_idx = '0;
  logic [2:0] cfg_cur = '0, cfg_nxt = '0;
  logic [15:0] cfg_val = '0;
  logic [47:0] eth_dst, eth_src;
  logic [15:0] eth_type, vlan_type, route_type;
  logic [2:0] vlan_pcp;
  logic vlan_cfi, parse_err, parse_done;
  logic [11:0] vlan_vid;
  logic [31:0] route_tag;
  logic [3:0] hdr_valid;

  int checks = 0, errors = 0, done_seen = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  hp_parser u0 (.*);

  always @(negedge clk) if (parse_done) done_seen++;

  typedef struct packed {
    logic [7:0] len; logic [15:0] et1; logic [15:0] tci; logic [15:0] et2;
    logic [31:0] route; logic [15:0] et3; logic [3:0] hv; logic err;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{8'd30, 16'h0800, 16'h0000, 16'h0000, 32'h0,        16'h0,    4'b1001, 1'b0},
    '{8'd30, 16'h8100, 16'h6123, 16'h0800, 32'h0,        16'h0,    4'b1011, 1'b0},
    '{8'd32, 16'h9100, 16'hA00F, 16'hAAAA, 32'h11223344, 16'h0800, 4'b1111, 1'b0},
    '{8'd28, 16'h8100, 16'h0FFF, 16'hAAAA, 32'h0A0B0C0D, 16'h1234, 4'b0111, 1'b0},
    '{8'd24, 16'h8100, 16'h2001, 16'h86DD, 32'h0,        16'h0,    4'b0011, 1'b0},
    '{8'd20, 16'h88CC, 16'h0000, 16'h0000, 32'h0,        16'h0,    4'b0001, 1'b1},
    '{8'd10, 16'h0800, 16'h0000, 16'h0000, 32'h0,        16'h0,    4'b0000, 1'b1},
    '{8'd16, 16'h8100, 16'h0000, 16'h0000, 32'h0,        16'h0,    4'b0001, 1'b1},
    '{8'd14, 16'h0800, 16'h0000, 16'h0000, 32'h0,        16'h0,    4'b1001, 1'b0},
    '{8'd14, 16'h8100, 16'h0000, 16'h0000, 32'h0,        16'h0,    4'b0001, 1'b1},
    '{8'd22, 16'h8100, 16'h0003, 16'hAAAA, 32'h55667788, 16'h0800, 4'b0011, 1'b1}
  };

  function automatic logic [7:0] pkt_byte(vec_t v, int i);
    if (i < 6)  return 8'hD0 + 8'(i);
    if (i < 12) return 8'h40 + 8'(i);
    case (i)
      12: return v.et1[15:8];   13: return v.et1[7:0];
      14: return v.tci[15:8];   15: return v.tci[7:0];
      16: return v.et2[15:8];   17: return v.et2[7:0];
      18: return v.route[31:24]; 19: return v.route[23:16];
      20: return v.route[15:8]; 21: return v.route[7:0];
      22: return v.et3[15:8];   23: return v.et3[7:0];
      default: return 8'hEE;
    endcase
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic write_rule(int idx, bit en, logic [2:0] cur, bit wild,
                            logic [15:0] val, logic [2:0] nxt);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 4'(idx); cfg_en = en; cfg_cur = cur;
    cfg_wild = wild; cfg_val = val; cfg_nxt = nxt;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send(vec_t v, int gap, bit hold_cfg, bit probe);
    done_seen = 0;
    for (int i = 0; i < int'(v.len); i++) begin
      @(negedge clk);
      if (probe && i == 1) begin
        chk("R11 valid cleared by first byte", 64'(hdr_valid), 64'd0);
        chk("R11 error cleared by first byte", 64'(parse_err), 64'd0);
      end
      in_valid = 1; in_byte = pkt_byte(v, i); in_last = (i == int'(v.len) - 1);
      cfg_we = hold_cfg;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        in_valid = 0; in_last = 0;
        cfg_we = hold_cfg && (i != int'(v.len) - 1);
      end
    end
    @(negedge clk);
    in_valid = 0; in_last = 0; cfg_we = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic judge(vec_t v, string ctx);
    chk({ctx, " R3 R6 hdr_valid"}, 64'(hdr_valid), 64'(v.hv));
    chk({ctx, " R5 R7 parse_err"}, 64'(parse_err), 64'(v.err));
    chk({ctx, " R9 one done"}, 64'(done_seen), 64'd1);
    if (v.hv[0]) chk({ctx, " R1 eth_type"}, 64'(eth_type), 64'(v.et1));
    if (v.hv[1]) begin
      chk({ctx, " R2 vlan fields"}, {vlan_pcp, vlan_cfi, vlan_vid}, 64'(v.tci));
      chk({ctx, " R2 vlan_type"}, 64'(vlan_type), 64'(v.et2));
    end
    if (v.hv[2]) begin
      chk({ctx, " R2 route_tag"}, 64'(route_tag), 64'(v.route));
      chk({ctx, " R2 route_type"}, 64'(route_type), 64'(v.et3));
    end
  endtask

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    chk("R11 reset hdr_valid", 64'(hdr_valid), 64'd0);
    chk("R11 reset parse_err", 64'(parse_err), 64'd0);
    chk("R9 reset parse_done", 64'(parse_done), 64'd0);
    rst_n = 1;

    // default program: states ETH=1 VLAN=2 RTAG=3 IPV4=4 STOP=5
    write_rule(0, 1, 3'd1, 0, 16'h8100, 3'd2);
    write_rule(1, 1, 3'd1, 0, 16'h9100, 3'd2);
    write_rule(2, 1, 3'd1, 0, 16'h0800, 3'd4);
    write_rule(3, 1, 3'd2, 0, 16'hAAAA, 3'd3);
    write_rule(4, 1, 3'd2, 0, 16'h0800, 3'd4);
    write_rule(5, 1, 3'd2, 1, 16'h0000, 3'd5);
    write_rule(6, 1, 3'd3, 0, 16'h0800, 3'd4);
    write_rule(7, 1, 3'd3, 1, 16'h0000, 3'd5);

    for (int k = 0; k < NV; k++) begin
      send(VECS[k], 0, 0, 0);
      judge(VECS[k], $sformatf("vec%0d", k));
      if (k == 0) begin
        chk("R1 eth_dst", 64'(eth_dst), 64'hD0D1D2D3D4D5);
        chk("R1 eth_src", 64'(eth_src), 64'h464748494A4B);
      end
    end

    // R12: stalls inside a packet
    send(VECS[2], 2, 0, 0);
    judge(VECS[2], "R12 stalled");

    // R10: write held through a busy packet must be dropped
    @(negedge clk);
    cfg_idx = 4'd2; cfg_en = 1; cfg_cur = 3'd1; cfg_wild = 0;
    cfg_val = 16'h0800; cfg_nxt = 3'd5;
    send(VECS[0], 1, 1, 0);
    chk("R10 busy write dropped", 64'(hdr_valid), 64'b1001);
    send(VECS[0], 0, 0, 0);
    chk("R10 rule intact after busy write", 64'(hdr_valid), 64'b1001);

    // R8: VLAN loops back to VLAN
    write_rule(4, 1, 3'd2, 0, 16'h8100, 3'd2);
    v = '{8'd30, 16'h8100, 16'h2005, 16'h8100, 32'h0, 16'h0, 4'b0011, 1'b1};
    send(v, 0, 0, 0);
    judge(v, "R8 revisit");
    write_rule(4, 1, 3'd2, 0, 16'h0800, 3'd4);

    // R11: results of an errored packet cleared at the next first byte
    send(VECS[5], 0, 0, 0);
    send(VECS[0], 0, 0, 1);
    judge(VECS[0], "R11 after error");

    // R4: wildcard at index 8 catches only what lower indices miss
    write_rule(8, 1, 3'd1, 1, 16'h0000, 3'd5);
    v = '{8'd20, 16'h88CC, 16'h0, 16'h0, 32'h0, 16'h0, 4'b0001, 1'b0};
    send(v, 0, 0, 0);
    judge(v, "R4 wildcard catch");
    send(VECS[0], 0, 0, 0);
    chk("R4 lower index wins", 64'(hdr_valid), 64'b1001);
    write_rule(0, 1, 3'd1, 1, 16'h0000, 3'd5);
    send(VECS[2], 0, 0, 0);
    chk("R4 index 0 wildcard beats index 1", 64'(hdr_valid), 64'b0001);
    chk("R4 no error on wildcard stop", 64'(parse_err), 64'd0);
    // disabled rules never match
    write_rule(0, 0, 3'd1, 1, 16'h0000, 3'd5);
    write_rule(8, 0, 3'd1, 1, 16'h0000, 3'd5);
    v = '{8'd20, 16'h88CC, 16'h0, 16'h0, 32'h0, 16'h0, 4'b0001, 1'b1};
    send(v, 0, 0, 0);
    judge(v, "R4 disabled rules");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R9 act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule